// File: doc/BRIEF.md
# Prioritized Timer Interrupt Controller

This block takes single-cycle underflow pulses from three timer channels and folds them into one interrupt request for a processor. Each channel has a sticky pending flag, a mask bit and a three-bit priority level. All of them sit in a small register bank on a simple synchronous bus. Among the channels that are both pending and unmasked, the one with the highest level wins. When two levels are equal, the lower channel number wins.

The winner's level is compared against the processor's current interrupt level and its global enable. The request goes out only when the winner's level is strictly higher and the global enable is 1. Alongside the request the block drives the winning level, the vector number and the vector address. All outputs are registered.

Top module: `tmr_irq_arb`

## Requirements
- R1: A 1 on uf_pulse[k] sets channel k's pending flag on that clock edge, whatever channel k's mask bit holds.
- R2: Writing a 1 to a flag bit at offset 0x00 clears that flag, and writing 0 leaves it unchanged. A pulse in the same cycle as a clear leaves the flag set.
- R3: A pending channel can win only while its mask bit is 1. Clearing the mask bit removes the request but leaves the flag set.
- R4: Among the pending, unmasked channels the highest level wins. On equal levels channel 0 beats 1, and 1 beats 2.
- R5: irq_req is 1 only when cpu_ie is 1 and the winner's level is strictly greater than cpu_lvl.
- R6: For winning channel k, irq_vec_num = 13+k and irq_vec_addr = 0x8000 + 4*irq_vec_num. With no winner, irq_lvl, irq_vec_num and irq_vec_addr are 0.
- R7: The register map is as follows:
  - offset 0x00: flags in bits 9+k.
  - offset 0x02: mask bits in bits 9+k.
  - offset 0x0E: channel 0's level in bits [10:8].
  - offset 0x10: channel 1's level in bits [2:0] and channel 2's level in bits [10:8].
  - All other bits read 0.
- R8: A channel whose level is 0 never produces irq_req.
- R9: Reset clears flags, masks, levels and all outputs. The outputs reflect the register state and the cpu inputs one clock edge after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uf_pulse | input | 3 | Underflow pulse, one per channel |
| bus_addr | input | 5 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| cpu_ie | input | 1 | Processor global interrupt enable |
| cpu_lvl | input | 3 | Processor current interrupt level |
| irq_req | output | 1 | Registered interrupt request |
| irq_lvl | output | 3 | Level of the winning channel |
| irq_vec_num | output | 8 | Vector number of the winning channel |
| irq_vec_addr | output | 16 | Vector address of the winning channel |

## Verification
A flag can see a set and a clear in the same cycle: an underflow pulse on a channel arrives on the same edge as a write-1 to that channel's flag bit. The bench provokes this directly on channel 2 and then reads the flag register back, where the flag must still read as set. It provokes it again through random pulse and write traffic. A cycle-accurate bench model applies the clear first and the set after it, and every output and readback is judged against that model.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
   localparam int unsigned OFS_FLAG  = 'h00;
   localparam int unsigned OFS_MASK  = 'h02;
   localparam int unsigned OFS_LVL0  = 'h0E;
   localparam int unsigned FIELD_LSB = 9;
   localparam int unsigned LVL_HI    = 8;

   // level register slot: channel k uses slot k+1, two slots per register
   function automatic int unsigned lvl_reg_ofs(input int unsigned ch);
      return OFS_LVL0 + 2 * ((ch + 1) / 2);
   endfunction

   function automatic int unsigned lvl_bit_lsb(input int unsigned ch);
      return (((ch + 1) % 2) == 1) ? LVL_HI : 0;
   endfunction
endpackage

// File: rtl/tmr_irq_regs.sv
module tmr_irq_regs
   import tmr_irq_pkg::*;
#(
   parameter int unsigned NCH    = 3,
   parameter int unsigned LVL_W  = 3,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NCH-1:0]       uf_pulse,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_we,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic [NCH-1:0]       flags,
   output logic [NCH-1:0]       masks,
   output logic [NCH*LVL_W-1:0] levels
);
   logic hit_flag, hit_mask;
   logic [DATA_W-1:0] rd_lvl [NCH];

   assign hit_flag = (bus_addr == ADDR_W'(OFS_FLAG));
   assign hit_mask = (bus_addr == ADDR_W'(OFS_MASK));

   for (genvar k = 0; k < NCH; k++) begin : g_ch
      localparam int unsigned OFS = lvl_reg_ofs(k);
      localparam int unsigned LSB = lvl_bit_lsb(k);
      logic             f_q, m_q;
      logic [LVL_W-1:0] l_q;
      logic             hit_l;

      assign hit_l = (bus_addr == ADDR_W'(OFS));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            f_q <= 1'b0;
            m_q <= 1'b0;
            l_q <= '0;
         end else begin
            f_q <= (f_q & ~(bus_we & hit_flag & bus_wdata[FIELD_LSB+k])) | uf_pulse[k];
            if (bus_we && hit_mask) m_q <= bus_wdata[FIELD_LSB+k];
            if (bus_we && hit_l)    l_q <= bus_wdata[LSB +: LVL_W];
         end
      end

      assign flags[k]                = f_q;
      assign masks[k]                = m_q;
      assign levels[k*LVL_W +: LVL_W] = l_q;
      assign rd_lvl[k] = hit_l ? (DATA_W'(l_q) << LSB) : '0;
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_flag) bus_rdata[FIELD_LSB +: NCH] = flags;
      if (hit_mask) bus_rdata[FIELD_LSB +: NCH] = masks;
      for (int k = 0; k < NCH; k++) bus_rdata = bus_rdata | rd_lvl[k];
   end
endmodule

// File: rtl/tmr_irq_pick.sv
module tmr_irq_pick #(
   parameter int unsigned NCH   = 3,
   parameter int unsigned LVL_W = 3,
   parameter int unsigned IDX_W = 2
) (
   input  logic [NCH-1:0]       cand,
   input  logic [NCH*LVL_W-1:0] levels,
   output logic                 win_valid,
   output logic [IDX_W-1:0]     win_idx,
   output logic [LVL_W-1:0]     win_lvl
);
   // scan upward; a later channel replaces only on a strictly higher level
   always_comb begin
      win_valid = 1'b0;
      win_idx   = '0;
      win_lvl   = '0;
      for (int k = 0; k < NCH; k++) begin
         if (cand[k] && (!win_valid || levels[k*LVL_W +: LVL_W] > win_lvl)) begin
            win_valid = 1'b1;
            win_idx   = IDX_W'(k);
            win_lvl   = levels[k*LVL_W +: LVL_W];
         end
      end
   end
endmodule

// File: rtl/tmr_irq_arb.sv
module tmr_irq_arb
   import tmr_irq_pkg::*;
#(
   parameter int unsigned NCH        = 3,
   parameter int unsigned LVL_W      = 3,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned VADDR_W    = 16,
   parameter int unsigned VEC_BASE   = 13,
   parameter int unsigned VADDR_BASE = 'h8000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NCH-1:0]       uf_pulse,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_we,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic                 cpu_ie,
   input  logic [LVL_W-1:0]     cpu_lvl,
   output logic                 irq_req,
   output logic [LVL_W-1:0]     irq_lvl,
   output logic [VEC_W-1:0]     irq_vec_num,
   output logic [VADDR_W-1:0]   irq_vec_addr
);
   localparam int unsigned IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

   if (NCH < 1 || FIELD_LSB + NCH > DATA_W) begin : g_bad_nch
      $error("tmr_irq_arb: channel field does not fit the data width");
   end
   if (LVL_W < 1 || LVL_W > LVL_HI || LVL_HI + LVL_W > DATA_W) begin : g_bad_lvl
      $error("tmr_irq_arb: level field does not fit its slot");
   end
   if (lvl_reg_ofs(NCH - 1) >= (1 << ADDR_W)) begin : g_bad_addr
      $error("tmr_irq_arb: address width too small for level registers");
   end
   if (VEC_BASE + NCH > (1 << VEC_W)) begin : g_bad_vec
      $error("tmr_irq_arb: vector numbers exceed VEC_W");
   end

   logic [NCH-1:0]       flags, masks;
   logic [NCH*LVL_W-1:0] levels;
   logic                 win_valid;
   logic [IDX_W-1:0]     win_idx;
   logic [LVL_W-1:0]     win_lvl;
   logic [VEC_W-1:0]     vec_num_d;
   logic [VADDR_W-1:0]   vec_addr_d;
   logic                 req_d;

   tmr_irq_regs #(
      .NCH(NCH), .LVL_W(LVL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .uf_pulse(uf_pulse),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .flags(flags), .masks(masks), .levels(levels)
   );

   tmr_irq_pick #(
      .NCH(NCH), .LVL_W(LVL_W), .IDX_W(IDX_W)
   ) u_pick (
      .cand(flags & masks), .levels(levels),
      .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl)
   );

   assign vec_num_d  = win_valid ? VEC_W'(VEC_BASE) + VEC_W'(win_idx) : '0;
   assign vec_addr_d = win_valid ? VADDR_W'(VADDR_BASE) + (VADDR_W'(vec_num_d) << 2) : '0;
   assign req_d      = cpu_ie && win_valid && (win_lvl > cpu_lvl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_req      <= 1'b0;
         irq_lvl      <= '0;
         irq_vec_num  <= '0;
         irq_vec_addr <= '0;
      end else begin
         irq_req      <= req_d;
         irq_lvl      <= win_valid ? win_lvl : '0;
         irq_vec_num  <= vec_num_d;
         irq_vec_addr <= vec_addr_d;
      end
   end
endmodule

// File: rtl/tmr_irq_chk.sv
module tmr_irq_chk #(
   parameter int unsigned NCH        = 3,
   parameter int unsigned LVL_W      = 3,
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned VADDR_W    = 16,
   parameter int unsigned VEC_BASE   = 13,
   parameter int unsigned VADDR_BASE = 'h8000
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NCH-1:0]     uf_pulse,
   input logic [NCH-1:0]     flags,
   input logic               cpu_ie,
   input logic [LVL_W-1:0]   cpu_lvl,
   input logic               irq_req,
   input logic [LVL_W-1:0]   irq_lvl,
   input logic [VEC_W-1:0]   irq_vec_num,
   input logic [VADDR_W-1:0] irq_vec_addr
);
   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (uf_pulse != '0) |=> ((flags & $past(uf_pulse)) == $past(uf_pulse))); // R1
   AST_REQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> $past(cpu_ie)); // R5
   AST_REQ_ABOVE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_lvl > $past(cpu_lvl))); // R5
   AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_vec_num >= VEC_W'(VEC_BASE) && irq_vec_num < VEC_W'(VEC_BASE + NCH))); // R6
   AST_VEC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_vec_addr == VADDR_W'(VADDR_BASE) + (VADDR_W'(irq_vec_num) << 2))); // R6
   AST_NO_ZERO_LVL: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_lvl != '0)); // R8
endmodule

bind tmr_irq_arb tmr_irq_chk #(
   .NCH(NCH), .LVL_W(LVL_W), .VEC_W(VEC_W), .VADDR_W(VADDR_W),
   .VEC_BASE(VEC_BASE), .VADDR_BASE(VADDR_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .uf_pulse(uf_pulse), .flags(flags),
   .cpu_ie(cpu_ie), .cpu_lvl(cpu_lvl), .irq_req(irq_req), .irq_lvl(irq_lvl),
   .irq_vec_num(irq_vec_num), .irq_vec_addr(irq_vec_addr)
);

// File: tb/sim_tmr_irq_arb.sv
module sim_tmr_irq_arb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  uf_pulse = '0;
   logic [4:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        cpu_ie = 1'b0;
   logic [2:0]  cpu_lvl = '0;
   logic        irq_req;
   logic [2:0]  irq_lvl;
   logic [7:0]  irq_vec_num;
   logic [15:0] irq_vec_addr;

   int total = 0;
   int bad = 0;

   // model state
   logic [2:0] m_flag = '0, m_mask = '0;
   logic [2:0] m_lvl [3] = '{3'd0, 3'd0, 3'd0};

   always #2.5 clk = ~clk;

   tmr_irq_arb u0 (
      .clk(clk), .rst_n(rst_n), .uf_pulse(uf_pulse), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cpu_ie(cpu_ie), .cpu_lvl(cpu_lvl), .irq_req(irq_req), .irq_lvl(irq_lvl),
      .irq_vec_num(irq_vec_num), .irq_vec_addr(irq_vec_addr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic model_out(input logic ie, input logic [2:0] cl,
                            output logic req, output logic [2:0] lv,
                            output logic [7:0] vn, output logic [15:0] va);
      logic v = 1'b0;
      int   w = 0;
      lv = '0;
      for (int k = 0; k < 3; k++)
         if (m_flag[k] && m_mask[k] && (!v || m_lvl[k] > lv)) begin
            v = 1'b1; w = k; lv = m_lvl[k];
         end
      vn  = v ? 8'(13 + w) : 8'd0;
      va  = v ? 16'h8000 + 16'(4 * (13 + w)) : 16'd0;
      req = ie && v && (lv > cl);
   endtask

   task automatic step(input logic [2:0] uf, input logic we, input logic [4:0] a,
                       input logic [15:0] wd, input logic ie, input logic [2:0] cl,
                       input string tag);
      logic e_req; logic [2:0] e_lv; logic [7:0] e_vn; logic [15:0] e_va;
      @(negedge clk);
      uf_pulse = uf; bus_we = we; bus_addr = a; bus_wdata = wd;
      cpu_ie = ie; cpu_lvl = cl;
      @(posedge clk);
      model_out(ie, cl, e_req, e_lv, e_vn, e_va);
      if (we && a == 5'h00) m_flag = m_flag & ~wd[11:9];
      m_flag = m_flag | uf;
      if (we && a == 5'h02) m_mask = wd[11:9];
      if (we && a == 5'h0E) m_lvl[0] = wd[10:8];
      if (we && a == 5'h10) begin m_lvl[1] = wd[2:0]; m_lvl[2] = wd[10:8]; end
      #1;
      chk({tag, " req"},  32'(irq_req), 32'(e_req));
      chk({tag, " lvl"},  32'(irq_lvl), 32'(e_lv));
      chk({tag, " vnum"}, 32'(irq_vec_num), 32'(e_vn));
      chk({tag, " vaddr"}, 32'(irq_vec_addr), 32'(e_va));
   endtask

   task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
      @(negedge clk);
      uf_pulse = '0; bus_we = 1'b0; bus_addr = a;
      #1;
      chk(tag, 32'(bus_rdata), 32'(exp));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1;
      chk("R9 reset req", 32'(irq_req), 0);
      chk("R9 reset vaddr", 32'(irq_vec_addr), 0);
      @(negedge clk);
      rst_n = 1'b1;
      rd(5'h00, 16'h0000, "R9 R7 flag reg after reset");
      rd(5'h10, 16'h0000, "R9 R7 level reg after reset");

      // R1: pulse with mask off sets the flag
      step(3'b010, 0, 0, 0, 1, 0, "R1 pulse masked");
      rd(5'h00, 16'h0400, "R1 flag set with mask 0");
      step(3'b000, 0, 0, 0, 1, 0, "R3 masked no req");
      // R7 map: level ch1 = 5 in low bits of 0x10, mask ch1
      step(3'b000, 1, 5'h10, 16'h0005, 1, 2, "R7 write lvl");
      step(3'b000, 1, 5'h02, 16'h0400, 1, 2, "R7 write mask");
      rd(5'h10, 16'h0005, "R7 level reg readback");
      rd(5'h02, 16'h0400, "R7 mask reg readback");
      step(3'b000, 0, 0, 0, 1, 2, "R9 one edge delay");
      chk("R5 req level 5 over 2", 32'(irq_req), 1);
      chk("R6 vnum ch1", 32'(irq_vec_num), 14);
      chk("R6 vaddr ch1", 32'(irq_vec_addr), 32'h8038);
      step(3'b000, 0, 0, 0, 1, 5, "R5 equal level");
      chk("R5 no req at equal level", 32'(irq_req), 0);
      step(3'b000, 0, 0, 0, 1, 4, "R5 strictly above");
      step(3'b000, 0, 0, 0, 0, 0, "R5 ie off");
      chk("R5 no req with ie 0", 32'(irq_req), 0);
      // R3: unmask removes request, flag stays
      step(3'b000, 1, 5'h02, 16'h0000, 1, 0, "R3 unmask");
      step(3'b000, 0, 0, 0, 1, 0, "R3 unmasked");
      chk("R3 no req after unmask", 32'(irq_req), 0);
      rd(5'h00, 16'h0400, "R3 flag kept after unmask");
      // R4 tie and level order
      step(3'b111, 1, 5'h0E, 16'h0300, 1, 0, "R4 set all");
      step(3'b000, 1, 5'h10, 16'h0303, 1, 0, "R4 equal levels");
      step(3'b000, 1, 5'h02, 16'h0E00, 1, 0, "R4 mask all");
      step(3'b000, 0, 0, 0, 1, 0, "R4 tie");
      chk("R4 tie goes to ch0", 32'(irq_vec_num), 13);
      step(3'b000, 1, 5'h10, 16'h0603, 1, 0, "R4 raise ch2");
      step(3'b000, 0, 0, 0, 1, 0, "R4 ch2 wins");
      chk("R4 ch2 highest", 32'(irq_vec_num), 15);
      chk("R6 vaddr ch2", 32'(irq_vec_addr), 32'h803C);
      // R2: write 0 no effect, then set beats clear
      step(3'b000, 1, 5'h00, 16'h0000, 1, 0, "R2 write zero");
      rd(5'h00, 16'h0E00, "R2 write 0 keeps flags");
      step(3'b100, 1, 5'h00, 16'h0800, 1, 0, "R2 set with clear");
      rd(5'h00, 16'h0E00, "R2 set beats clear");
      step(3'b000, 1, 5'h00, 16'h0600, 1, 0, "R2 clear ch0 ch1");
      rd(5'h00, 16'h0800, "R2 w1c cleared");
      step(3'b000, 1, 5'h00, 16'h0E00, 1, 0, "R2 clear all");
      step(3'b000, 0, 0, 0, 1, 0, "R6 none pending");
      chk("R6 zero vector none", 32'(irq_vec_num), 0);
      // R8: level 0 never requests
      step(3'b001, 1, 5'h0E, 16'h0000, 1, 0, "R8 lvl0");
      step(3'b000, 1, 5'h02, 16'h0200, 1, 0, "R8 mask ch0");
      step(3'b000, 0, 0, 0, 1, 0, "R8 check");
      chk("R8 level 0 no req", 32'(irq_req), 0);
      chk("R8 winner still ch0", 32'(irq_vec_num), 13);

      // random traffic
      for (int i = 0; i < 3000; i++) begin
         logic [4:0] a;
         logic [2:0] uf;
         uf = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
         case ($urandom % 4)
            0: a = 5'h00; 1: a = 5'h02; 2: a = 5'h0E; default: a = 5'h10;
         endcase
         step(uf, ($urandom % 3) == 0, a, 16'($urandom), ($urandom % 5) != 0,
              3'($urandom), "R1 R2 R3 R4 R5 R6 R8 random");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule